// File: doc/BRIEF.md
# Machine CSR Write Legalizer

This block is the machine-level control and status register file of a 32-bit core. It has one write port (address, data, enable) and one read port (address in, data and an illegal-access flag out). Every write passes through a per-register legalizer before storage. Fields that are not implemented are dropped. The previous-machine-privilege field is forced onto a legal privilege. The summary dirty bit is recomputed. The vector and exception-PC registers get their low bits cleared. The ISA register follows the rules that apply when extensions are disabled.

The supervisor interrupt-enable and interrupt-pending views have no storage of their own. They read and write the machine registers through the interrupt delegation mask. The implemented privilege modes come from the reset ISA value: supervisor mode is present when bit 18 is set, and user mode when bit 20 is set. A read of any address that is not implemented returns zero and raises the illegal flag.

Top module: `mcsr_legalizer`

## Requirements
- R1: After reset, the status register reads as zero except for its previous-privilege field (bits 12:11), which holds the legalized form of 0. The ISA register reads the `RESET_ISA` parameter (default 0x4014112D). Every other register reads zero.
- R2: Writes keep only these bits. Pending register (0x344): bits 1 and 5. Enable register (0x304): bits 1, 3, 5, 7, 9 and 12. Interrupt delegation (0x303): bits 1, 5, 9 and 12. Exception delegation (0x302): bits 0, 3, 8, 12, 13 and 15.
- R3: A write to status bits 12:11 is legalized. Without user mode the field reads 3. Otherwise a value of 2 becomes 0, and a value of 1 becomes 0 when supervisor mode is absent.
- R4: Status (0x300) stores bits 1, 3, 5, 7, 13, 14 and 17 to 22. It also stores bit 8 only with supervisor mode, and bits 16:15 only when `HAS_X` is set. Bit 31 is read-only and reads 1 exactly when bits 14:13 or bits 16:15 are both ones.
- R5: A write to the ISA register (0x301) is ignored entirely when it clears bit 2 while `pc_b1` is 1. A written bit 5 of 0 also forces bit 3 to 0. Only bits 0, 2, 3, 5 and 12 that are set in `RESET_ISA` can change.
- R6: Writes clear low bits before storage. Machine vector (0x305): bit 1. Supervisor vector (0x105): bits 1:0. Machine and supervisor exception PCs (0x341, 0x141): bit 0.
- R7: The supervisor enable view (0x104) reads the enable register AND the interrupt delegation register. A write through it changes only the delegated bits of the enable register.
- R8: The supervisor pending view (0x144) reads the pending register AND the delegation register. A write through it changes only pending bit 1, and only while delegation bit 1 is set.
- R9: A read of an address not listed in R2 to R8 returns 0 with `rd_illegal` high. `rd_illegal` is low for every listed address.
- R10: While ISA bit 2 is clear, reads of both exception PCs return bit 1 as 0. The stored value is kept and reappears when bit 2 is set again.
- R11: A write sampled at a rising edge is visible on the read port right after that edge. Reads are combinational. Writes to unimplemented addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write register address |
| wr_data | input | 32 | Write data before legalization |
| pc_b1 | input | 1 | Bit 1 of the current program counter |
| rd_addr | input | 12 | Read register address |
| rd_data | output | 32 | Read data, zero on illegal access |
| rd_illegal | output | 1 | Read address is not implemented |

## Verification
Read data and the illegal flag are combinational in `rd_addr`, so both are due in the same cycle the address is presented. A write takes effect at the rising edge that samples `wr_en`, so its legalized value is due on the read port straight after that edge. The bench drives all inputs at falling edges. Its behavioural model updates at the rising edge from the same sampled inputs. Both the per-cycle comparison and the directed checks sample a few time units after the falling edge, when every result of the preceding rising edge has settled. A second instance without supervisor mode, user mode or the extension-state field covers the other legalization outcomes.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int CSR_W  = 32;
  localparam int ADDR_W = 12;
  localparam int NVEC   = 4;
  typedef logic [CSR_W-1:0]  word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // register addresses
  localparam addr_t AD_MSTATUS = 12'h300;
  localparam addr_t AD_MISA    = 12'h301;
  localparam addr_t AD_MEDELEG = 12'h302;
  localparam addr_t AD_MIDELEG = 12'h303;
  localparam addr_t AD_MIE     = 12'h304;
  localparam addr_t AD_MTVEC   = 12'h305;
  localparam addr_t AD_MEPC    = 12'h341;
  localparam addr_t AD_MIP     = 12'h344;
  localparam addr_t AD_SIE     = 12'h104;
  localparam addr_t AD_STVEC   = 12'h105;
  localparam addr_t AD_SEPC    = 12'h141;
  localparam addr_t AD_SIP     = 12'h144;

  // interrupt bit positions
  localparam int IB_SSW = 1;
  localparam int IB_MSW = 3;
  localparam int IB_STM = 5;
  localparam int IB_MTM = 7;
  localparam int IB_SEX = 9;
  localparam int IB_COP = 12;

  localparam word_t PEND_WMASK  = (word_t'(1) << IB_SSW) | (word_t'(1) << IB_STM);
  localparam word_t SPEND_WMASK = word_t'(1) << IB_SSW;
  localparam word_t DELEG_IMASK = (word_t'(1) << IB_SSW) | (word_t'(1) << IB_STM)
                                | (word_t'(1) << IB_SEX) | (word_t'(1) << IB_COP);
  localparam word_t ENABLE_MASK = DELEG_IMASK | (word_t'(1) << IB_MSW) | (word_t'(1) << IB_MTM);

  // exception causes that may be delegated: 0,3,8,12,13,15
  localparam word_t EXC_DMASK = 32'h0000_B109;

  // status field positions
  localparam int ST_SPP = 8;
  localparam int ST_MPP = 11;
  localparam int ST_FS  = 13;
  localparam int ST_XS  = 15;
  localparam int ST_SD  = 31;
  localparam word_t ST_BASE_WMASK = 32'h007E_60AA;
  localparam word_t ST_XS_MASK    = 32'h0001_8000;
  localparam word_t ST_SPP_MASK   = word_t'(1) << ST_SPP;

  // ISA letter positions
  localparam int IL_A = 0;
  localparam int IL_C = 2;
  localparam int IL_D = 3;
  localparam int IL_F = 5;
  localparam int IL_M = 12;
  localparam int IL_S = 18;
  localparam int IL_U = 20;
  localparam word_t ISA_SOFT = (word_t'(1) << IL_A) | (word_t'(1) << IL_C) | (word_t'(1) << IL_D)
                             | (word_t'(1) << IL_F) | (word_t'(1) << IL_M);

  // privilege codes
  localparam logic [1:0] PV_U = 2'd0;
  localparam logic [1:0] PV_S = 2'd1;
  localparam logic [1:0] PV_R = 2'd2;
  localparam logic [1:0] PV_M = 2'd3;

  // low bits cleared per vector entry: sepc, mepc, stvec, mtvec
  localparam logic [NVEC-1:0][CSR_W-1:0] VEC_CLR = {32'h1, 32'h1, 32'h3, 32'h2};
  localparam int VI_MTVEC = 0;
  localparam int VI_STVEC = 1;
  localparam int VI_MEPC  = 2;
  localparam int VI_SEPC  = 3;

  function automatic word_t merge_bits(input word_t old_v, input word_t new_v, input word_t m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [1:0] fix_prev_priv(input logic [1:0] req, input logic has_s,
                                               input logic has_u);
    if (!has_u) return PV_M;
    if (req == PV_R || (req == PV_S && !has_s)) return PV_U;
    return req;
  endfunction

  function automatic word_t status_next(input word_t old_v, input word_t wd, input logic has_s,
                                        input logic has_u, input logic has_x);
    word_t m;
    word_t n;
    m = ST_BASE_WMASK | (has_x ? ST_XS_MASK : '0) | (has_s ? ST_SPP_MASK : '0);
    n = merge_bits(old_v, wd, m);
    n[ST_MPP+:2] = fix_prev_priv(wd[ST_MPP+:2], has_s, has_u);
    n[ST_SD]     = (&n[ST_FS+:2]) | (&n[ST_XS+:2]);
    return n;
  endfunction

  function automatic word_t isa_next(input word_t old_v, input word_t wd, input logic pc1,
                                     input word_t rst_isa);
    word_t v;
    if (!wd[IL_C] && pc1) return old_v;
    v = wd;
    if (!v[IL_F]) v[IL_D] = 1'b0;
    return merge_bits(old_v, v, ISA_SOFT & rst_isa);
  endfunction

  function automatic word_t pc_read_mask(input word_t isa_v);
    return isa_v[IL_C] ? '1 : ~(word_t'(1) << 1);
  endfunction
endpackage

// File: rtl/mcsr_status_reg.sv
module mcsr_status_reg
  import mcsr_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_X = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wd,
  output word_t q
);
  localparam word_t RST_VAL = status_next('0, '0, HAS_S, HAS_U, HAS_X);

  word_t st_d;
  assign st_d = status_next(q, wd, HAS_S, HAS_U, HAS_X);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= st_d;
  end

  // R3
  mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[ST_MPP+:2] != PV_R) && (HAS_U || q[ST_MPP+:2] == PV_M)
    && (HAS_S || q[ST_MPP+:2] != PV_S));

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/mcsr_intr_regs.sv
module mcsr_intr_regs
  import mcsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_pend,
  input  logic  we_en,
  input  logic  we_ideleg,
  input  logic  we_edeleg,
  input  logic  we_sen,
  input  logic  we_spend,
  input  word_t wd,
  output word_t pend_q,
  output word_t en_q,
  output word_t idel_q,
  output word_t edel_q
);
  word_t pend_d, en_d, idel_d, edel_d;

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    idel_d = idel_q;
    edel_d = edel_q;
    if (we_pend)   pend_d = merge_bits(pend_q, wd, PEND_WMASK);
    if (we_spend)  pend_d = merge_bits(pend_q, wd, SPEND_WMASK & idel_q);
    if (we_en)     en_d   = merge_bits(en_q, wd, ENABLE_MASK);
    if (we_sen)    en_d   = merge_bits(en_q, wd, ENABLE_MASK & idel_q);
    if (we_ideleg) idel_d = merge_bits(idel_q, wd, DELEG_IMASK);
    if (we_edeleg) edel_d = merge_bits(edel_q, wd, EXC_DMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      idel_q <= '0;
      edel_q <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      idel_q <= idel_d;
      edel_q <= edel_d;
    end
  end

  // R2
  deleg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((idel_q & ~DELEG_IMASK) == '0) && ((edel_q & ~EXC_DMASK) == '0));

  // R2
  enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~ENABLE_MASK) == '0) && ((pend_q & ~PEND_WMASK) == '0));

  // R7
  sen_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_sen |=> ((en_q & ~$past(idel_q)) == ($past(en_q) & ~$past(idel_q))));

  // R8
  spend_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_spend |=> (pend_q[IB_STM] == $past(pend_q[IB_STM])));
endmodule

// File: rtl/mcsr_isa_reg.sv
module mcsr_isa_reg
  import mcsr_pkg::*;
#(
  parameter word_t RESET_ISA = 32'h4014_112D
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wd,
  input  logic  pc1,
  output logic  blocked,
  output word_t q
);
  assign blocked = we && !wd[IL_C] && pc1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_ISA;
    else if (we) q <= isa_next(q, wd, pc1, RESET_ISA);
  end

  // R5
  isa_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(q));

  // R5
  isa_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~ISA_SOFT) == (RESET_ISA & ~ISA_SOFT));

  // R5
  isa_d_needs_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wd[IL_F] && !blocked) |=> !q[IL_D]);
endmodule

// File: rtl/mcsr_vec_regs.sv
module mcsr_vec_regs
  import mcsr_pkg::*;
#(
  parameter int N = NVEC,
  parameter logic [N-1:0][CSR_W-1:0] CLR = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             we,
  input  word_t                    wd,
  output logic [N-1:0][CSR_W-1:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    word_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q <= '0;
      else if (we[i]) ent_q <= wd & ~CLR[i];
    end
    assign q[i] = ent_q;

    // R6
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_q & CLR[i]) == '0);
  end
endmodule

// File: rtl/mcsr_legalizer.sv
module mcsr_legalizer
  import mcsr_pkg::*;
#(
  parameter word_t RESET_ISA = 32'h4014_112D,
  parameter bit    HAS_X     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CSR_W-1:0]  wr_data,
  input  logic              pc_b1,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CSR_W-1:0]  rd_data,
  output logic              rd_illegal
);
  localparam bit HAS_S = RESET_ISA[IL_S];
  localparam bit HAS_U = RESET_ISA[IL_U];

  word_t status_q, isa_q, pend_q, en_q, idel_q, edel_q;
  logic [NVEC-1:0][CSR_W-1:0] vec_q;
  logic [NVEC-1:0] vec_we;
  logic isa_blocked;

  logic we_status, we_isa, we_pend, we_en, we_idel, we_edel, we_sen, we_spend;
  assign we_status = wr_en && (wr_addr == AD_MSTATUS);
  assign we_isa    = wr_en && (wr_addr == AD_MISA);
  assign we_pend   = wr_en && (wr_addr == AD_MIP);
  assign we_en     = wr_en && (wr_addr == AD_MIE);
  assign we_idel   = wr_en && (wr_addr == AD_MIDELEG);
  assign we_edel   = wr_en && (wr_addr == AD_MEDELEG);
  assign we_sen    = wr_en && (wr_addr == AD_SIE);
  assign we_spend  = wr_en && (wr_addr == AD_SIP);
  assign vec_we[VI_MTVEC] = wr_en && (wr_addr == AD_MTVEC);
  assign vec_we[VI_STVEC] = wr_en && (wr_addr == AD_STVEC);
  assign vec_we[VI_MEPC]  = wr_en && (wr_addr == AD_MEPC);
  assign vec_we[VI_SEPC]  = wr_en && (wr_addr == AD_SEPC);

  mcsr_status_reg #(.HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_X(HAS_X)) u_status (
    .clk(clk), .rst_n(rst_n), .we(we_status), .wd(wr_data), .q(status_q));

  mcsr_isa_reg #(.RESET_ISA(RESET_ISA)) u_isa (
    .clk(clk), .rst_n(rst_n), .we(we_isa), .wd(wr_data), .pc1(pc_b1),
    .blocked(isa_blocked), .q(isa_q));

  mcsr_intr_regs u_intr (
    .clk(clk), .rst_n(rst_n), .we_pend(we_pend), .we_en(we_en), .we_ideleg(we_idel),
    .we_edeleg(we_edel), .we_sen(we_sen), .we_spend(we_spend), .wd(wr_data),
    .pend_q(pend_q), .en_q(en_q), .idel_q(idel_q), .edel_q(edel_q));

  mcsr_vec_regs #(.N(NVEC), .CLR(VEC_CLR)) u_vec (
    .clk(clk), .rst_n(rst_n), .we(vec_we), .wd(wr_data), .q(vec_q));

  word_t pc_mask;
  assign pc_mask = pc_read_mask(isa_q);

  always_comb begin
    rd_illegal = 1'b0;
    case (rd_addr)
      AD_MSTATUS: rd_data = status_q;
      AD_MISA:    rd_data = isa_q;
      AD_MEDELEG: rd_data = edel_q;
      AD_MIDELEG: rd_data = idel_q;
      AD_MIE:     rd_data = en_q;
      AD_MIP:     rd_data = pend_q;
      AD_MTVEC:   rd_data = vec_q[VI_MTVEC];
      AD_STVEC:   rd_data = vec_q[VI_STVEC];
      AD_MEPC:    rd_data = vec_q[VI_MEPC] & pc_mask;
      AD_SEPC:    rd_data = vec_q[VI_SEPC] & pc_mask;
      AD_SIE:     rd_data = en_q & idel_q;
      AD_SIP:     rd_data = pend_q & idel_q;
      default: begin
        rd_data    = '0;
        rd_illegal = 1'b1;
      end
    endcase
  end

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_illegal |-> (rd_data == '0));

  // R7
  sie_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AD_SIE) |-> ((rd_data & ~idel_q) == '0));

  // R10
  epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr == AD_MEPC || rd_addr == AD_SEPC) && !isa_q[IL_C]) |-> !rd_data[1]);

  // R5
  isa_blocked_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isa_blocked |-> we_isa);
endmodule

// File: tb/mcsr_legalizer_bench.sv
module mcsr_legalizer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = 12'h0;
  logic [31:0] wr_data = 32'h0;
  logic pc_b1 = 1'b0;
  logic [11:0] rd_addr = 12'h300;
  logic [31:0] rd_data, rd_data_mo;
  logic rd_illegal, rd_illegal_mo;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcsr_legalizer u_mcsr_legalizer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_b1(pc_b1), .rd_addr(rd_addr), .rd_data(rd_data), .rd_illegal(rd_illegal));

  // configuration without supervisor, user or extension-state field
  mcsr_legalizer #(.RESET_ISA(32'h4000_112D), .HAS_X(1'b0)) u_mcsr_legalizer_mo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_b1(pc_b1), .rd_addr(rd_addr), .rd_data(rd_data_mo), .rd_illegal(rd_illegal_mo));

  // behavioural model of the default configuration
  logic [31:0] m_st, m_isa, m_med, m_mid, m_mie, m_mip, m_mtvec, m_stvec, m_mepc, m_sepc;

  task automatic mdl_reset();
    m_st = 0; m_isa = 32'h4014_112D; m_med = 0; m_mid = 0; m_mie = 0; m_mip = 0;
    m_mtvec = 0; m_stvec = 0; m_mepc = 0; m_sepc = 0;
  endtask

  task automatic mdl_write(input logic [11:0] a, input logic [31:0] d, input logic p1);
    logic [31:0] t;
    case (a)
      12'h300: begin
        t = m_st;
        t[1] = d[1]; t[3] = d[3]; t[5] = d[5]; t[7] = d[7]; t[8] = d[8];
        t[14:13] = d[14:13]; t[16:15] = d[16:15]; t[22:17] = d[22:17];
        t[12:11] = (d[12:11] == 2'b10) ? 2'b00 : d[12:11];
        t[31] = (t[14:13] == 2'b11) || (t[16:15] == 2'b11);
        m_st = t;
      end
      12'h301: if (d[2] || !p1) begin
        t = m_isa;
        t[0] = d[0]; t[2] = d[2]; t[5] = d[5]; t[12] = d[12]; t[3] = d[3] & d[5];
        m_isa = t;
      end
      12'h302: m_med = d & 32'h0000_B109;
      12'h303: m_mid = d & 32'h0000_1222;
      12'h304: m_mie = d & 32'h0000_12AA;
      12'h344: m_mip = d & 32'h0000_0022;
      12'h305: m_mtvec = {d[31:2], 1'b0, d[0]};
      12'h105: m_stvec = {d[31:2], 2'b00};
      12'h341: m_mepc = {d[31:1], 1'b0};
      12'h141: m_sepc = {d[31:1], 1'b0};
      12'h104: for (int i = 0; i < 32; i++) if (m_mid[i]) m_mie[i] = d[i];
      12'h144: if (m_mid[1]) m_mip[1] = d[1];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] mdl_read(input logic [11:0] a);
    case (a)
      12'h300: return m_st;
      12'h301: return m_isa;
      12'h302: return m_med;
      12'h303: return m_mid;
      12'h304: return m_mie;
      12'h344: return m_mip;
      12'h305: return m_mtvec;
      12'h105: return m_stvec;
      12'h341: return m_isa[2] ? m_mepc : (m_mepc & ~32'h2);
      12'h141: return m_isa[2] ? m_sepc : (m_sepc & ~32'h2);
      12'h104: return m_mie & m_mid;
      12'h144: return m_mip & m_mid;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic mdl_known(input logic [11:0] a);
    return a inside {12'h300, 12'h301, 12'h302, 12'h303, 12'h304, 12'h344,
                     12'h305, 12'h105, 12'h341, 12'h141, 12'h104, 12'h144};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mdl_reset();
    else if (wr_en) mdl_write(wr_addr, wr_data, pc_b1);
  end

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R11: every cycle, compare the read port against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      #3;
      check("R11 per-cycle data", rd_data, mdl_read(rd_addr));
      check("R9 per-cycle illegal", {31'b0, rd_illegal}, {31'b0, !mdl_known(rd_addr)});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1 reset state
    rd(12'h300, "R1 status reset", 32'h0);
    check("R1 status reset no-U instance", rd_data_mo, 32'h0000_1800);
    rd(12'h301, "R1 isa reset", 32'h4014_112D);
    rd(12'h304, "R1 enable reset", 32'h0);
    rd(12'h341, "R1 mepc reset", 32'h0);

    // R2 write masks
    wr(12'h304, 32'hFFFF_FFFF); rd(12'h304, "R2 enable mask", 32'h0000_12AA);
    wr(12'h344, 32'hFFFF_FFFF); rd(12'h344, "R2 pending mask", 32'h0000_0022);
    wr(12'h303, 32'hFFFF_FFFF); rd(12'h303, "R2 int delegation mask", 32'h0000_1222);
    wr(12'h302, 32'hFFFF_FFFF); rd(12'h302, "R2 exc delegation mask", 32'h0000_B109);

    // R3 previous-privilege legalization
    wr(12'h300, 32'h0000_1000); rd(12'h300, "R3 mpp 2 becomes U", 32'h0);
    wr(12'h300, 32'h0000_0800); rd(12'h300, "R3 mpp S kept", 32'h0000_0800);
    check("R3 no-U instance reads M", rd_data_mo, 32'h0000_1800);
    wr(12'h300, 32'h0000_1800); rd(12'h300, "R3 mpp M kept", 32'h0000_1800);

    // R4 status fields and summary dirty bit
    wr(12'h300, 32'h0000_6000); rd(12'h300, "R4 fs dirty sets sd", 32'h8000_6000);
    wr(12'h300, 32'h0001_8000); rd(12'h300, "R4 xs dirty sets sd", 32'h8001_8000);
    check("R4 no-X instance drops xs", rd_data_mo, 32'h0000_1800);
    wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, "R4 all ones", 32'h807F_F9AA);
    check("R4 no-S instance drops spp", rd_data_mo, 32'h807E_78AA);
    wr(12'h300, 32'h8000_0000); rd(12'h300, "R4 sd read-only", 32'h0);

    // R5 ISA register rules
    pc_b1 = 1'b1;
    wr(12'h301, 32'h4014_0129); rd(12'h301, "R5 write ignored with pc bit1", 32'h4014_112D);
    pc_b1 = 1'b0;
    wr(12'h301, 32'h4014_0129); rd(12'h301, "R5 clear M and C", 32'h4014_0129);
    wr(12'h301, 32'h4014_112D); rd(12'h301, "R5 restore", 32'h4014_112D);
    wr(12'h301, 32'h4014_110D); rd(12'h301, "R5 F clear forces D clear", 32'h4014_1105);
    wr(12'h301, 32'h4010_112F); rd(12'h301, "R5 only reset letters change", 32'h4014_112D);

    // R6 low-bit clearing
    wr(12'h305, 32'hFFFF_FFFF); rd(12'h305, "R6 mtvec", 32'hFFFF_FFFD);
    wr(12'h105, 32'hFFFF_FFFF); rd(12'h105, "R6 stvec", 32'hFFFF_FFFC);
    wr(12'h341, 32'hFFFF_FFFF); rd(12'h341, "R6 mepc", 32'hFFFF_FFFE);
    wr(12'h141, 32'hFFFF_FFFF); rd(12'h141, "R6 sepc", 32'hFFFF_FFFE);

    // R10 exception PC readback without compressed
    wr(12'h301, 32'h4014_1129);
    rd(12'h341, "R10 mepc bit1 hidden", 32'hFFFF_FFFC);
    rd(12'h141, "R10 sepc bit1 hidden", 32'hFFFF_FFFC);
    wr(12'h301, 32'h4014_112D);
    rd(12'h341, "R10 mepc bit1 back", 32'hFFFF_FFFE);

    // R7 supervisor enable view
    wr(12'h303, 32'h0000_0022);
    rd(12'h104, "R7 sie view", 32'h0000_0022);
    wr(12'h104, 32'h0);
    rd(12'h304, "R7 only delegated cleared", 32'h0000_1288);
    rd(12'h104, "R7 sie after clear", 32'h0);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h304, "R7 delegated set", 32'h0000_12AA);

    // R8 supervisor pending view
    wr(12'h344, 32'h0);
    wr(12'h144, 32'hFFFF_FFFF);
    rd(12'h344, "R8 only ssw written", 32'h0000_0002);
    rd(12'h144, "R8 sip view", 32'h0000_0002);
    wr(12'h303, 32'h0000_0020);
    wr(12'h144, 32'h0);
    rd(12'h344, "R8 undelegated ssw ignored", 32'h0000_0002);

    // R9 illegal reads
    rd(12'h7C0, "R9 illegal data", 32'h0);
    check("R9 illegal flag", {31'b0, rd_illegal}, 32'h1);
    rd(12'h340, "R9 scratch not implemented", 32'h0);
    check("R9 illegal flag scratch", {31'b0, rd_illegal}, 32'h1);

    // R11 write to unimplemented address changes nothing
    wr(12'h340, 32'hFFFF_FFFF);
    rd(12'h300, "R11 status untouched", 32'h0);
    rd(12'h344, "R11 pending untouched", 32'h0000_0002);

    repeat (2) @(negedge clk);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule